// File: doc/BRIEF.md
# Reconfigurable Dual-Port Memory Tile

This block is a 4096-bit storage tile. Two independent ports, A and B, use it. Each port has its own address, write data and write enable, and both ports may act in the same clock cycle. A static width setting sets the word size to 1, 2, 4 or 8 bits. The address space grows or shrinks to match, so the tile always holds 4096 bits. The storage is organised as 512 physical rows of 8 bits. In the narrower widths, the high address bits pick a row and the low address bits pick a lane inside that row.

A second static setting selects one of four behaviours. The first is a true dual-port RAM. The second is a single-port RAM that uses port A only. The third is a read-only table, filled from a seeded initial image whenever reset is asserted. The fourth is a synchronous FIFO that reuses the same rows: port A pushes, port B pops, and full and empty flags are produced. Two parameters each add one register stage: one on the input side of both ports, and one on the read-data outputs. This lets a designer trade latency for timing margin. Both static settings may only change while reset is held.

Top module: `dual_port_tile`

## Requirements
- R1: While reset is high, every row r (0..511) is loaded with the byte r[7:0] XOR (r[8] shifted to bit 7) XOR INIT_SEED (default 8'hA5), and both read outputs are cleared to zero.
- R2: Width code 0, 1, 2 and 3 means 1, 2, 4 and 8 bits. The row is the address shifted right by (3 - code). The lane is the remaining low address bits, and lane k occupies row bits k*width upward. Read data sits in the low bits of the read output, with the upper bits zero. A write changes only its own lane.
- R3: With both register stages off, read data for an address presented before a clock edge is on the output after that edge. Each enabled stage adds exactly one cycle.
- R4: In dual-port mode (mode code 0), both ports read and write independent addresses in the same cycle.
- R5: When both ports write overlapping bits of the same row in one cycle, port A's bits are stored. Non-overlapping lanes of the same row both take effect.
- R6: A read of a location that is being written in the same cycle returns the data held before that write.
- R7: In single-port mode (mode code 1), port B writes are ignored and b_rdata stays zero, while port A reads and writes normally.
- R8: In table mode (mode code 2), writes on both ports are ignored and both ports read the initial image.
- R9: In FIFO mode (mode code 3), a_we pushes the low width bits of a_wdata, and b_re pops. Popped words appear on b_rdata one cycle after the pop, in push order. Capacity is 4096 divided by the width.
- R10: fifo_empty is high when no word is stored, and fifo_full is high when capacity is reached. A push while full and a pop while empty are ignored, and b_rdata then keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset; loads the image |
| cfg_width | input | 2 | Word width code (0:1, 1:2, 2:4, 3:8 bits) |
| cfg_mode | input | 2 | Behaviour code (0 dual, 1 single, 2 table, 3 FIFO) |
| a_addr | input | 12 | Port A address |
| a_wdata | input | 8 | Port A write data (low bits used) |
| a_we | input | 1 | Port A write enable / FIFO push |
| b_addr | input | 12 | Port B address |
| b_wdata | input | 8 | Port B write data (low bits used) |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | FIFO pop request (ignored in RAM modes) |
| a_rdata | output | 8 | Port A read data |
| b_rdata | output | 8 | Port B read data |
| fifo_full | output | 1 | FIFO has no free entry |
| fifo_empty | output | 1 | FIFO holds no entry |

## Verification
Random traffic on a small window of rows, run at every width, forces same-row collisions. A design that picked the wrong winner, or that lost the other lane of a shared row, would corrupt data on the next read. The same traffic catches a design that returned freshly written data instead of the old data. In FIFO mode the bench fills the tile to capacity, pushes once more, and drains it. It also pops on an empty FIFO and runs push-with-pop streams. A pointer that advanced on an ignored request would show up as a wrong flag or as out-of-order data. A second instance with both register stages enabled confirms that the data arrives exactly two cycles later than on the unregistered instance, not earlier or later.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int ROW_W   = 8;
    localparam int ROWS    = 512;
    localparam int ADDR_W  = 12;
    localparam int ROW_AW  = $clog2(ROWS);
    localparam int LANE_AW = $clog2(ROW_W);
    localparam int CNT_W   = ADDR_W + 1;

    typedef enum logic [1:0] {WID_X1, WID_X2, WID_X4, WID_X8} wid_e;
    typedef enum logic [1:0] {MODE_DUAL, MODE_SINGLE, MODE_ROM, MODE_FIFO} mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  wdata;
        logic              we;
    } port_req_t;

    function automatic logic [1:0] lane_shift(input wid_e w);
        return 2'd3 - w;
    endfunction

    function automatic logic [ROW_AW-1:0] row_of(input logic [ADDR_W-1:0] addr, input wid_e w);
        logic [ADDR_W-1:0] s;
        s = addr >> lane_shift(w);
        return s[ROW_AW-1:0];
    endfunction

    function automatic logic [LANE_AW-1:0] lane_of(input logic [ADDR_W-1:0] addr, input wid_e w);
        logic [ADDR_W-1:0] m;
        m = (ADDR_W'(1) << lane_shift(w)) - ADDR_W'(1);
        m = addr & m;
        return m[LANE_AW-1:0];
    endfunction

    function automatic logic [5:0] lane_off(input logic [LANE_AW-1:0] lane, input wid_e w);
        return {3'b000, lane} << w;
    endfunction

    function automatic logic [ROW_W-1:0] lane_mask(input logic [LANE_AW-1:0] lane, input wid_e w);
        logic [15:0] m;
        logic [4:0]  bits;
        bits = 5'd1 << w;
        m = (16'd1 << bits) - 16'd1;
        m = m << lane_off(lane, w);
        return m[ROW_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] lane_get(input logic [ROW_W-1:0] row,
                                                  input logic [LANE_AW-1:0] lane, input wid_e w);
        logic [ROW_W-1:0] s;
        s = row >> lane_off(lane, w);
        return s & lane_mask('0, w);
    endfunction

    function automatic logic [ROW_W-1:0] lane_put(input logic [ROW_W-1:0] data,
                                                  input logic [LANE_AW-1:0] lane, input wid_e w);
        logic [ROW_W-1:0] s;
        s = data & lane_mask('0, w);
        return s << lane_off(lane, w);
    endfunction

    function automatic logic [CNT_W-1:0] depth_of(input wid_e w);
        return CNT_W'(ROWS * ROW_W) >> w;
    endfunction

    function automatic logic [ROW_W-1:0] image_byte(input logic [ROW_AW-1:0] r, input logic [ROW_W-1:0] seed);
        return r[7:0] ^ {r[8], 7'b0} ^ seed;
    endfunction

endpackage

// File: rtl/dpm_pipe.sv
module dpm_pipe #(
    parameter int W  = 8,
    parameter bit EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/dpm_fifo_ctrl.sv
module dpm_fifo_ctrl
    import dpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wid_e              wid,
    input  logic              push_req,
    input  logic              pop_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic [ADDR_W-1:0] wr_idx,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              full,
    output logic              empty
);
    logic              wr_wrap, rd_wrap;
    logic [CNT_W-1:0]  depth;
    logic [ADDR_W-1:0] last;

    assign depth   = depth_of(wid);
    assign last    = ADDR_W'(depth - CNT_W'(1));
    assign empty   = (wr_idx == rd_idx) && (wr_wrap == rd_wrap);
    assign full    = (wr_idx == rd_idx) && (wr_wrap != rd_wrap);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            rd_idx  <= '0;
            wr_wrap <= 1'b0;
            rd_wrap <= 1'b0;
        end else begin
            if (push_ok) begin
                if (wr_idx == last) begin
                    wr_idx  <= '0;
                    wr_wrap <= !wr_wrap;
                end else begin
                    wr_idx <= wr_idx + ADDR_W'(1);
                end
            end
            if (pop_ok) begin
                if (rd_idx == last) begin
                    rd_idx  <= '0;
                    rd_wrap <= !rd_wrap;
                end else begin
                    rd_idx <= rd_idx + ADDR_W'(1);
                end
            end
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(full && empty)); // R10
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(wr_idx) < depth) && (CNT_W'(rd_idx) < depth)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) full |=> $stable(wr_idx)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) empty |=> $stable(rd_idx)); // R10
endmodule

// File: rtl/dpm_array.sv
module dpm_array
    import dpm_pkg::*;
#(
    parameter logic [ROW_W-1:0] INIT_SEED = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  wid_e              wid,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ROW_W-1:0]  a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [ROW_W-1:0]  b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [ROW_W-1:0]  a_rd,
    output logic [ROW_W-1:0]  b_rd
);
    logic [ROW_W-1:0]   mem [ROWS];
    logic [ROW_AW-1:0]  a_row, b_row;
    logic [LANE_AW-1:0] a_lane, b_lane;
    logic [ROW_W-1:0]   a_msk, b_msk, a_pl, b_pl;
    logic [ROW_W-1:0]   b_next, ab_next;

    assign a_row  = row_of(a_addr, wid);
    assign b_row  = row_of(b_addr, wid);
    assign a_lane = lane_of(a_addr, wid);
    assign b_lane = lane_of(b_addr, wid);
    assign a_msk  = lane_mask(a_lane, wid);
    assign b_msk  = lane_mask(b_lane, wid);
    assign a_pl   = lane_put(a_wdata, a_lane, wid);
    assign b_pl   = lane_put(b_wdata, b_lane, wid);

    // Port B merged first, port A on top: A owns any shared bits.
    assign b_next  = (mem[b_row] & ~b_msk) | (b_pl & b_msk);
    assign ab_next = (b_next & ~a_msk) | (a_pl & a_msk);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= image_byte(ROW_AW'(r), INIT_SEED);
            end
            a_rd <= '0;
            b_rd <= '0;
        end else begin
            if (a_re) a_rd <= lane_get(mem[a_row], a_lane, wid);
            if (b_re) b_rd <= lane_get(mem[b_row], b_lane, wid);
            if (a_we && b_we && (a_row == b_row)) begin
                mem[a_row] <= ab_next;
            end else begin
                if (b_we) mem[b_row] <= b_next;
                if (a_we) mem[a_row] <= (mem[a_row] & ~a_msk) | (a_pl & a_msk);
            end
        end
    end

    AST_A_BITS_LAND: assert property (@(posedge clk) disable iff (rst)
        a_we |=> ((mem[$past(a_row)] & $past(a_msk)) == ($past(a_pl) & $past(a_msk)))); // R5
endmodule

// File: rtl/dual_port_tile.sv
module dual_port_tile
    import dpm_pkg::*;
#(
    parameter bit               IN_REG    = 1'b0,
    parameter bit               OUT_REG   = 1'b0,
    parameter logic [7:0]       INIT_SEED = 8'hA5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_width,
    input  logic [1:0]  cfg_mode,
    input  logic [11:0] a_addr,
    input  logic [7:0]  a_wdata,
    input  logic        a_we,
    input  logic [11:0] b_addr,
    input  logic [7:0]  b_wdata,
    input  logic        b_we,
    input  logic        b_re,
    output logic [7:0]  a_rdata,
    output logic [7:0]  b_rdata,
    output logic        fifo_full,
    output logic        fifo_empty
);
    localparam int REQ_W = $bits(port_req_t);

    wid_e              wid;
    mode_e             mode;
    port_req_t         a_in, b_in, a_q, b_q;
    logic              b_re_q;
    logic              push_ok, pop_ok;
    logic [ADDR_W-1:0] wr_idx, rd_idx;
    logic [ADDR_W-1:0] a_adr_eff, b_adr_eff;
    logic              a_we_eff, b_we_eff, a_re_eff, b_re_eff;
    logic [ROW_W-1:0]  a_arr, b_arr;
    logic              is_fifo;

    assign wid     = wid_e'(cfg_width);
    assign mode    = mode_e'(cfg_mode);
    assign is_fifo = (mode == MODE_FIFO);

    assign a_in = '{addr: a_addr, wdata: a_wdata, we: a_we};
    assign b_in = '{addr: b_addr, wdata: b_wdata, we: b_we};

    dpm_pipe #(.W(REQ_W), .EN(IN_REG)) u_in_a (.clk(clk), .rst(rst), .d(a_in), .q(a_q));
    dpm_pipe #(.W(REQ_W), .EN(IN_REG)) u_in_b (.clk(clk), .rst(rst), .d(b_in), .q(b_q));
    dpm_pipe #(.W(1),     .EN(IN_REG)) u_in_p (.clk(clk), .rst(rst), .d(b_re), .q(b_re_q));

    dpm_fifo_ctrl u_fifo (
        .clk(clk), .rst(rst), .wid(wid),
        .push_req(a_q.we && is_fifo), .pop_req(b_re_q && is_fifo),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_idx(wr_idx), .rd_idx(rd_idx),
        .full(fifo_full), .empty(fifo_empty)
    );

    always_comb begin
        a_adr_eff = a_q.addr;
        b_adr_eff = b_q.addr;
        a_we_eff  = 1'b0;
        b_we_eff  = 1'b0;
        a_re_eff  = 1'b1;
        b_re_eff  = 1'b1;
        unique case (mode)
            MODE_DUAL: begin
                a_we_eff = a_q.we;
                b_we_eff = b_q.we;
            end
            MODE_SINGLE: begin
                a_we_eff = a_q.we;
                b_re_eff = 1'b0;
            end
            MODE_ROM: begin
            end
            MODE_FIFO: begin
                a_adr_eff = wr_idx;
                b_adr_eff = rd_idx;
                a_we_eff  = push_ok;
                a_re_eff  = 1'b0;
                b_re_eff  = pop_ok;
            end
            default: begin
            end
        endcase
    end

    dpm_array #(.INIT_SEED(INIT_SEED)) u_array (
        .clk(clk), .rst(rst), .wid(wid),
        .a_addr(a_adr_eff), .a_wdata(a_q.wdata), .a_we(a_we_eff), .a_re(a_re_eff),
        .b_addr(b_adr_eff), .b_wdata(b_q.wdata), .b_we(b_we_eff), .b_re(b_re_eff),
        .a_rd(a_arr), .b_rd(b_arr)
    );

    dpm_pipe #(.W(ROW_W), .EN(OUT_REG)) u_out_a (.clk(clk), .rst(rst), .d(a_arr), .q(a_rdata));
    dpm_pipe #(.W(ROW_W), .EN(OUT_REG)) u_out_b (.clk(clk), .rst(rst), .d(b_arr), .q(b_rdata));

    AST_SINGLE_B_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE) |-> (b_rdata == '0)); // R7
endmodule

// File: tb/dual_port_tile_tb.sv
module dual_port_tile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_width = 2'd3;
    logic [1:0]  cfg_mode = 2'd0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [7:0]  a_wdata = '0, b_wdata = '0;
    logic        a_we = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic [7:0]  a_rdata, b_rdata, p_a_rdata, p_b_rdata;
    logic        fifo_full, fifo_empty, p_full, p_empty;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int md = 0;
    int wc = 3;
    int bm [512];
    int fq [4200];
    int head, tail;

    always #(CLK_PERIOD/2) clk = !clk;

    dual_port_tile u_dut (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .a_rdata(a_rdata), .b_rdata(b_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    dual_port_tile #(.IN_REG(1'b1), .OUT_REG(1'b1)) u_dut_pipe (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .a_rdata(p_a_rdata), .b_rdata(p_b_rdata), .fifo_full(p_full), .fifo_empty(p_empty)
    );

    function automatic int img(input int r);
        return ((r & 255) ^ (((r >> 8) & 1) << 7) ^ 8'hA5) & 255;
    endfunction

    function automatic int rowof(input int addr);
        return addr >> (3 - wc);
    endfunction

    function automatic int mrd(input int addr);
        int lane, bits;
        bits = 1 << wc;
        lane = addr & ((8 >> wc) - 1);
        return (bm[rowof(addr)] >> (lane * bits)) & ((1 << bits) - 1);
    endfunction

    task automatic mwr(input int addr, input int d);
        int lane, bits, mask, r;
        bits = 1 << wc;
        lane = addr & ((8 >> wc) - 1);
        mask = ((1 << bits) - 1) << (lane * bits);
        r = rowof(addr);
        bm[r] = ((bm[r] & ~mask) | ((d << (lane * bits)) & mask)) & 255;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int m, input int w);
        md = m; wc = w;
        rst = 1'b1;
        cfg_mode = 2'(m); cfg_width = 2'(w);
        a_we = 0; b_we = 0; b_re = 0; a_addr = 0; b_addr = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 512; r++) bm[r] = img(r);
    endtask

    task automatic cyc(input int aa, input int aw, input bit awe,
                       input int ba, input int bw, input bit bwe, input string tag);
        int ea, eb;
        string t;
        a_addr = 12'(aa); a_wdata = 8'(aw); a_we = awe;
        b_addr = 12'(ba); b_wdata = 8'(bw); b_we = bwe; b_re = 0;
        ea = mrd(aa);
        eb = (md == 1) ? 0 : mrd(ba);
        t = tag;
        if (t == "") begin
            if (awe && bwe && rowof(aa) == rowof(ba)) t = "R5";
            else if ((awe || bwe) && rowof(aa) == rowof(ba)) t = "R6";
            else t = "R4";
        end
        if (bwe && md == 0) mwr(ba, bw);
        if (awe && (md == 0 || md == 1)) mwr(aa, aw);
        @(negedge clk);
        a_we = 0; b_we = 0;
        chk(t, a_rdata, 8'(ea));
        chk(t, b_rdata, 8'(eb));
    endtask

    task automatic fcyc(input bit push, input int wd, input bit pop);
        a_we = push; a_wdata = 8'(wd); b_re = pop; b_we = 0;
        @(negedge clk);
        a_we = 0; b_re = 0;
    endtask

    task automatic fifo_run(input int w);
        int depth, msk, v, last;
        do_reset(3, w);
        depth = 4096 >> w;
        msk = (1 << (1 << w)) - 1;
        head = 0; tail = 0;
        chk("R10 empty after reset", 8'(fifo_empty), 8'd1);
        chk("R10 full after reset", 8'(fifo_full), 8'd0);
        fcyc(0, 0, 1);
        chk("R10 pop on empty keeps data", b_rdata, 8'd0);
        chk("R10 still empty", 8'(fifo_empty), 8'd1);
        for (int i = 0; i < depth; i++) begin
            v = $urandom & msk;
            fq[tail] = v; tail++;
            fcyc(1, v, 0);
            if (i == 0) chk("R10 not empty after push", 8'(fifo_empty), 8'd0);
            if (i == depth - 2) chk("R10 not full one short", 8'(fifo_full), 8'd0);
        end
        chk("R9 full at capacity", 8'(fifo_full), 8'd1);
        fcyc(1, ~fq[0] & msk, 0);
        chk("R10 full after dropped push", 8'(fifo_full), 8'd1);
        for (int i = 0; i < depth; i++) begin
            fcyc(0, 0, 1);
            chk("R9 pop order", b_rdata, 8'(fq[head]));
            head++;
        end
        last = fq[head - 1];
        chk("R10 empty after drain", 8'(fifo_empty), 8'd1);
        fcyc(0, 0, 1);
        chk("R10 pop on empty holds", b_rdata, 8'(last));
        v = $urandom & msk; fq[tail] = v; tail++;
        fcyc(1, v, 0);
        for (int k = 0; k < 8; k++) begin
            v = $urandom & msk; fq[tail] = v; tail++;
            fcyc(1, v, 1);
            chk("R9 push with pop", b_rdata, 8'(fq[head]));
            head++;
        end
        fcyc(0, 0, 1);
        chk("R9 final pop", b_rdata, 8'(fq[head]));
        head++;
        chk("R10 empty at end", 8'(fifo_empty), 8'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(0, 3);
        chk("R1 a_rdata reset", a_rdata, 8'd0);
        chk("R1 b_rdata reset", b_rdata, 8'd0);
        cyc(0, 0, 0, 511, 0, 0, "R1");
        cyc(255, 0, 0, 256, 0, 0, "R1");

        // R3: latency with and without both register stages
        do_reset(0, 3);
        a_addr = 12'd3;
        repeat (4) @(negedge clk);
        a_addr = 12'd5;
        @(negedge clk);
        chk("R3 unregistered latency", a_rdata, 8'(img(5)));
        a_addr = 12'd9;
        @(negedge clk);
        chk("R3 pipe not yet", p_a_rdata, 8'(img(3)));
        @(negedge clk);
        chk("R3 pipe two extra cycles", p_a_rdata, 8'(img(5)));
        @(negedge clk);
        chk("R3 pipe next word", p_a_rdata, 8'(img(9)));

        // R5 / R6 directed
        do_reset(0, 3);
        cyc(40, 8'h11, 1, 40, 8'h22, 1, "R5");
        cyc(40, 0, 0, 40, 0, 0, "R5");
        cyc(50, 8'h77, 1, 50, 0, 0, "R6");
        cyc(50, 0, 0, 50, 0, 0, "R6");
        do_reset(0, 0);
        cyc(8, 1, 1, 9, 0, 1, "R5");
        cyc(8, 0, 0, 9, 0, 0, "R5");

        // R2 lane mapping at width 2
        do_reset(0, 1);
        cyc(1, 3, 1, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(2, 0, 0, 3, 0, 0, "R2");

        // R4 random dual-port traffic at every width
        for (int w = 0; w < 4; w++) begin
            do_reset(0, w);
            for (int i = 0; i < 250; i++) begin
                cyc($urandom % (16 << (3 - w)), $urandom & 255, ($urandom % 2) == 1,
                    $urandom % (16 << (3 - w)), $urandom & 255, ($urandom % 2) == 1, "");
            end
        end

        // R7 single-port
        do_reset(1, 3);
        cyc(7, 0, 0, 7, 8'h3C, 1, "R7");
        cyc(7, 0, 0, 7, 0, 0, "R7");
        cyc(8, 8'h5A, 1, 0, 0, 0, "R7");
        cyc(8, 0, 0, 8, 0, 0, "R7");

        // R8 table mode
        do_reset(2, 3);
        cyc(7, 8'h12, 1, 9, 8'h34, 1, "R8");
        cyc(7, 0, 0, 9, 0, 0, "R8");
        do_reset(2, 2);
        cyc(20, 8'hF, 1, 21, 8'hF, 1, "R8");
        cyc(20, 0, 0, 21, 0, 0, "R8");

        fifo_run(3);
        fifo_run(2);
        fifo_run(0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule